// File: doc/BRIEF.md
# Atomic Read-Modify-Write Completer

This block carries out atomic memory operations on behalf of a requester. A request names an operation, a word address, a size, an operand and, for compare-and-swap, a compare value. The engine reads the addressed word from a local single-port synchronous memory and works out the replacement. It writes the replacement back when the operation calls for it. It then returns the value the word held before the operation as the completion.

Only one operation is in flight at a time. The request port drops ready on acceptance and raises it again only after the completion has been taken. The memory therefore never sees the read and write of one operation separated by another access. Memory words are 64 bits wide. A 32-bit operation works on the low half of the word and leaves the high half untouched. Hint and steering-tag inputs arrive with each request and have no influence on the result.

Top module: `atomic_rmw_engine`

## Requirements
- R1: After reset, req_ready is 1, cpl_valid is 0 and mem_en is 0, and mem_en is never asserted while req_ready is 1.
- R2: Operation code 2'b00 (fetch-and-add) writes old + operand back to the word, with the sum wrapping modulo the operand width, and returns the old value.
- R3: Operation code 2'b01 (swap) writes the operand to the word unconditionally and returns the old value.
- R4: Operation code 2'b10 (compare-and-swap) writes the operand when the compare value equals the current value, and returns the old value.
- R5: A compare-and-swap whose compare value differs from the current value makes no memory write and still returns the old value.
- R6: req_wide = 1 selects a 64-bit operation. req_wide = 0 selects a 32-bit operation on bits 31:0 of the word: bits 63:32 of the word are preserved, the compare uses bits 31:0 only, and cpl_data carries the old bits 31:0 with bits 63:32 zero.
- R7: Operation code 2'b11 is undefined. It makes no memory access and completes with cpl_status = 1 and cpl_data = 0. Every defined operation completes with cpl_status = 0.
- R8: req_ready falls in the cycle after a request is accepted and stays low until the cycle after the completion handshake (cpl_valid and cpl_ready both high).
- R9: While cpl_valid is high and cpl_ready is low, cpl_valid, cpl_data and cpl_status hold their values.
- R10: req_hint and req_stag have no effect on memory contents, completion values or timing.
- R11: A defined operation makes exactly one memory read, issued in the cycle after acceptance. Counting clock edges from the acceptance edge inclusive, cpl_valid rises after RD_LAT+3 edges when a write is made, after RD_LAT+2 when no write is made, and after 1 edge for an undefined operation. A write is always immediately followed by cpl_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept |
| req_op | input | 2 | Operation: 00 add, 01 swap, 10 compare-and-swap, 11 undefined |
| req_wide | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| req_addr | input | ADDR_W | Word address |
| req_opnd | input | DATA_W | Add or swap operand |
| req_cmp | input | DATA_W | Compare value |
| req_hint | input | 2 | Processing hint, ignored |
| req_stag | input | 8 | Steering tag, ignored |
| cpl_valid | output | 1 | Completion present |
| cpl_ready | input | 1 | Completion taken |
| cpl_data | output | DATA_W | Value before the operation |
| cpl_status | output | 1 | 0 success, 1 unsupported request |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Write when set with mem_en |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Read data, valid RD_LAT cycles after the read edge |

## Verification
Each result has a fixed due time measured in edges from the acceptance edge. An undefined operation completes after one edge. A compare-and-swap miss completes after RD_LAT+2 edges, and every writing operation after RD_LAT+3. The bench counts the edges it waits before cpl_valid appears and compares the count to the figure it predicts from the operation and the mirror's current word. The bench memory model counts reads and writes per operation, so a miss or undefined code that touches memory is caught. The ready flag is compared against the bench's own outstanding-request flag at every falling edge.

// File: rtl/atomic_pkg.sv
package atomic_pkg;
  typedef enum logic [1:0] {
    OP_FADD = 2'b00,
    OP_SWAP = 2'b01,
    OP_CAS  = 2'b10,
    OP_BAD  = 2'b11
  } atom_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDREQ,
    ST_WAIT,
    ST_WRITE,
    ST_RESP
  } eng_state_e;
endpackage

// File: rtl/atomic_alu.sv
module atomic_alu
  import atomic_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [1:0]        op,
  input  logic              wide,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] cmp,
  output logic [DATA_W-1:0] new_val,
  output logic              do_write
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] sum_full;
  logic [HALF-1:0]   sum_half;
  logic              eq_full;
  logic              eq_half;

  always_comb begin
    sum_full = old_val + opnd;
    sum_half = old_val[HALF-1:0] + opnd[HALF-1:0];
    eq_full  = (old_val == cmp);
    eq_half  = (old_val[HALF-1:0] == cmp[HALF-1:0]);
    new_val  = old_val;
    do_write = 1'b0;
    case (atom_op_e'(op))
      OP_FADD: begin
        do_write = 1'b1;
        new_val  = wide ? sum_full : {old_val[DATA_W-1:HALF], sum_half};
      end
      OP_SWAP: begin
        do_write = 1'b1;
        new_val  = wide ? opnd : {old_val[DATA_W-1:HALF], opnd[HALF-1:0]};
      end
      OP_CAS: begin
        do_write = wide ? eq_full : eq_half;
        new_val  = wide ? opnd : {old_val[DATA_W-1:HALF], opnd[HALF-1:0]};
      end
      default: begin
        do_write = 1'b0;
        new_val  = old_val;
      end
    endcase
  end
endmodule

// File: rtl/atomic_seq.sv
module atomic_seq
  import atomic_pkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_undef,
  input  logic cpl_ready,
  input  logic need_write,
  output logic req_ready,
  output logic accept,
  output logic rd_strobe,
  output logic wr_strobe,
  output logic capture,
  output logic cpl_valid
);
  localparam int CNT_W = $clog2(RD_LAT + 1);
  localparam logic [CNT_W-1:0] LAT_END = CNT_W'(RD_LAT);

  eng_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    accept    = req_ready && req_valid;
    rd_strobe = (state_q == ST_RDREQ);
    wr_strobe = (state_q == ST_WRITE);
    cpl_valid = (state_q == ST_RESP);
    capture   = (state_q == ST_WAIT) && (cnt_q == LAT_END);
    state_d   = state_q;
    cnt_d     = cnt_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = req_undef ? ST_RESP : ST_RDREQ;
      ST_RDREQ: begin
        state_d = ST_WAIT;
        cnt_d   = CNT_W'(1);
      end
      ST_WAIT: begin
        if (capture) state_d = need_write ? ST_WRITE : ST_RESP;
        else         cnt_d   = cnt_q + CNT_W'(1);
      end
      ST_WRITE: state_d = ST_RESP;
      ST_RESP:  if (cpl_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/atomic_rmw_engine.sv
module atomic_rmw_engine
  import atomic_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 64,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_opnd,
  input  logic [DATA_W-1:0] req_cmp,
  input  logic [1:0]        req_hint,
  input  logic [7:0]        req_stag,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [DATA_W-1:0] cpl_data,
  output logic              cpl_status,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int HALF = DATA_W / 2;

  logic [1:0]        op_q;
  logic              wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] opnd_q, cmp_q, old_q, old_src;
  logic              ur_q;
  logic              accept, rd_strobe, wr_strobe, capture, need_write;
  logic [DATA_W-1:0] new_val;
  logic              unused_side;

  assign unused_side = ^{req_hint, req_stag};

  atomic_seq #(.RD_LAT(RD_LAT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_undef  (req_op == OP_BAD),
    .cpl_ready  (cpl_ready),
    .need_write (need_write),
    .req_ready  (req_ready),
    .accept     (accept),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .capture    (capture),
    .cpl_valid  (cpl_valid)
  );

  assign old_src = capture ? mem_rdata : old_q;

  atomic_alu #(.DATA_W(DATA_W)) u_alu (
    .op       (op_q),
    .wide     (wide_q),
    .old_val  (old_src),
    .opnd     (opnd_q),
    .cmp      (cmp_q),
    .new_val  (new_val),
    .do_write (need_write)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      wide_q <= 1'b0;
      addr_q <= '0;
      opnd_q <= '0;
      cmp_q  <= '0;
      ur_q   <= 1'b0;
    end else if (accept) begin
      op_q   <= req_op;
      wide_q <= req_wide;
      addr_q <= req_addr;
      opnd_q <= req_opnd;
      cmp_q  <= req_cmp;
      ur_q   <= (req_op == OP_BAD);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       old_q <= '0;
    else if (capture) old_q <= mem_rdata;
    else if (accept)  old_q <= '0;
  end

  always_comb begin
    mem_en     = rd_strobe || wr_strobe;
    mem_we     = wr_strobe;
    mem_addr   = addr_q;
    mem_wdata  = new_val;
    cpl_status = ur_q;
    if (ur_q)        cpl_data = '0;
    else if (wide_q) cpl_data = old_q;
    else             cpl_data = {{(DATA_W-HALF){1'b0}}, old_q[HALF-1:0]};
  end
endmodule

// File: rtl/atomic_rmw_chk.sv
module atomic_rmw_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_op,
  input logic       cpl_valid,
  input logic       cpl_ready,
  input logic [63:0] cpl_data,
  input logic       cpl_status,
  input logic       mem_en,
  input logic       mem_we
);
  a_r1_mem_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !req_ready);

  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r8_busy_in_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !req_ready);

  a_r9_cpl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_data) && $stable(cpl_status)));

  a_r7_undef_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op == 2'b11) |=> (cpl_valid && cpl_status && !mem_en));

  a_r11_write_then_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> cpl_valid);
endmodule

bind atomic_rmw_engine atomic_rmw_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_op     (req_op),
  .cpl_valid  (cpl_valid),
  .cpl_ready  (cpl_ready),
  .cpl_data   (cpl_data),
  .cpl_status (cpl_status),
  .mem_en     (mem_en),
  .mem_we     (mem_we)
);

// File: tb/tb_atomic_rmw_engine.sv
`timescale 1ns/1ps
module tb_atomic_rmw_engine;
  localparam int AW    = 4;
  localparam int DW    = 64;
  localparam int LAT   = 2;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_wide, cpl_valid, cpl_ready, cpl_status;
  logic [1:0]    req_op, req_hint;
  logic [7:0]    req_stag;
  logic [AW-1:0] req_addr, mem_addr;
  logic [DW-1:0] req_opnd, req_cmp, cpl_data, mem_wdata, mem_rdata;
  logic          mem_en, mem_we;

  always #4 clk = ~clk;

  atomic_rmw_engine #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_wide(req_wide),
    .req_addr(req_addr), .req_opnd(req_opnd), .req_cmp(req_cmp),
    .req_hint(req_hint), .req_stag(req_stag),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_data(cpl_data), .cpl_status(cpl_status),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // behavioural memory with LAT-stage read pipe, plus access counters
  logic [DW-1:0] ram [WORDS];
  logic [DW-1:0] pipe [LAT];
  logic [DW-1:0] mirror [WORDS];
  int n_rd, n_wr;
  assign mem_rdata = pipe[LAT-1];

  always @(posedge clk) begin
    for (int i = LAT-1; i > 0; i--) pipe[i] <= pipe[i-1];
    if (mem_en && !mem_we) begin pipe[0] <= ram[mem_addr]; n_rd <= n_rd + 1; end
    if (mem_en && mem_we)  begin ram[mem_addr] <= mem_wdata; n_wr <= n_wr + 1; end
  end

  int vectors = 0;
  int miscompares = 0;
  bit outstanding = 1'b0;
  bit in_reset = 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison of ready against the bench's own busy flag (R8)
  always @(negedge clk) begin
    if (!in_reset) chk(req_ready == !outstanding, "R8 ready vs outstanding", 64'(req_ready), 64'(!outstanding));
  end

  task automatic predict(input logic [1:0] op, input bit wide, input logic [DW-1:0] old,
                         input logic [DW-1:0] opnd, input logic [DW-1:0] cmp,
                         output logic [DW-1:0] nv, output bit wr, output logic [DW-1:0] ret, output bit ur);
    logic [31:0] lo;
    nv = old; wr = 0; ur = (op == 2'b11);
    ret = ur ? 64'd0 : (wide ? old : {32'd0, old[31:0]});
    if (op == 2'b00) begin
      wr = 1;
      if (wide) nv = old + opnd;
      else begin lo = old[31:0] + opnd[31:0]; nv = {old[63:32], lo}; end
    end else if (op == 2'b01 || op == 2'b10) begin
      wr = (op == 2'b01) ? 1'b1 : (wide ? (old == cmp) : (old[31:0] == cmp[31:0]));
      if (wr) nv = wide ? opnd : {old[63:32], opnd[31:0]};
    end
  endtask

  task automatic atomic(input logic [1:0] op, input bit wide, input logic [AW-1:0] a,
                        input logic [DW-1:0] opnd, input logic [DW-1:0] cmp,
                        input int hold, input string tag);
    logic [DW-1:0] nv, ret, held;
    bit wr, ur;
    int waited, exp_lat;
    predict(op, wide, mirror[a], opnd, cmp, nv, wr, ret, ur);
    exp_lat = ur ? 1 : (wr ? LAT + 3 : LAT + 2);
    @(negedge clk);
    req_valid = 1; req_op = op; req_wide = wide; req_addr = a;
    req_opnd = opnd; req_cmp = cmp; req_hint = 2'($urandom); req_stag = 8'($urandom);
    n_rd = 0; n_wr = 0;
    @(posedge clk); outstanding = 1;
    @(negedge clk);
    req_valid = 0;
    waited = 1;
    while (!cpl_valid && waited < 50) begin @(negedge clk); waited++; end
    chk(waited == exp_lat, {tag, " R11 latency"}, 64'(waited), 64'(exp_lat));
    chk(cpl_data == ret, {tag, " data"}, cpl_data, ret);
    chk(cpl_status == ur, {tag, " R7 status"}, 64'(cpl_status), 64'(ur));
    chk(n_rd == (ur ? 0 : 1), {tag, " R11 reads"}, 64'(n_rd), 64'(ur ? 0 : 1));
    chk(n_wr == int'(wr), {tag, " R5 writes"}, 64'(n_wr), 64'(wr));
    held = cpl_data;
    for (int i = 0; i < hold; i++) begin
      req_valid = 1; req_op = 2'b01; req_addr = a; // must not be taken (R8)
      @(negedge clk);
      chk(cpl_valid && cpl_data == held, {tag, " R9 hold"}, cpl_data, held);
    end
    req_valid = 0;
    cpl_ready = 1;
    @(posedge clk); outstanding = 0;
    @(negedge clk);
    cpl_ready = 0;
    chk(!cpl_valid, {tag, " R8 released"}, 64'(cpl_valid), 64'd0);
    chk(n_wr == int'(wr) && n_rd == (ur ? 0 : 1), {tag, " R8 no extra access"}, 64'(n_wr), 64'(wr));
    if (wr) mirror[a] = nv;
    chk(ram[a] == mirror[a], {tag, " word"}, ram[a], mirror[a]);
  endtask

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; cpl_ready = 0; req_op = 0; req_wide = 0; req_addr = 0;
    req_opnd = 0; req_cmp = 0; req_hint = 0; req_stag = 0; n_rd = 0; n_wr = 0;
    for (int i = 0; i < LAT; i++) pipe[i] = '0;
    for (int i = 0; i < WORDS; i++) begin
      ram[i] = {32'(i * 32'h1111_0101), 32'hFFFF_FFF0 + 32'(i)};
      mirror[i] = ram[i];
    end
    repeat (3) @(negedge clk);
    chk(!cpl_valid && !mem_en && req_ready, "R1 reset state", {62'd0, cpl_valid, mem_en}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    in_reset = 0;
    chk(req_ready && !mem_en, "R1 after release", 64'(req_ready), 64'd1);

    atomic(2'b00, 1, 4'd1, 64'd5, 64'd0, 0, "R2 add wide");
    atomic(2'b00, 1, 4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 0, "R2 add wide wrap");
    atomic(2'b00, 0, 4'd3, 64'hAAAA_AAAA_0000_0020, 64'd0, 0, "R6 add narrow wrap");
    atomic(2'b01, 1, 4'd4, 64'h0123_4567_89AB_CDEF, 64'd0, 0, "R3 swap wide");
    atomic(2'b01, 0, 4'd5, 64'h5555_5555_1234_5678, 64'd0, 2, "R6 swap narrow");
    atomic(2'b10, 1, 4'd6, 64'hDEAD_BEEF_0000_0001, mirror[6], 0, "R4 cas hit");
    atomic(2'b10, 1, 4'd7, 64'h1, mirror[7] ^ 64'h1, 0, "R5 cas miss");
    atomic(2'b10, 0, 4'd8, 64'h77, {~mirror[8][63:32], mirror[8][31:0]}, 0, "R6 cas narrow hit");
    atomic(2'b10, 0, 4'd9, 64'h77, mirror[9] ^ 64'h100, 0, "R5 cas narrow miss");
    atomic(2'b11, 1, 4'd10, 64'h99, 64'h0, 3, "R7 undefined");
    atomic(2'b00, 1, 4'd1, 64'd7, 64'd0, 4, "R9 backpressure");

    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      logic [1:0] op;
      logic [DW-1:0] cv;
      a  = AW'($urandom);
      op = 2'($urandom);
      cv = ($urandom % 2) ? mirror[a] : {$urandom, $urandom};
      atomic(op, 1'($urandom), a, {$urandom, $urandom}, cv, int'($urandom % 3), "R10 random");
    end

    @(negedge clk);
    for (int i = 0; i < WORDS; i++)
      chk(ram[i] == mirror[i], "R2 final word", ram[i], mirror[i]);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule